// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches one bank of already-synchronized GPIO inputs and turns selected conditions on each pin into a latched event bit. Every pin has its own trigger choice. A type bit picks edge or level detection. A polarity bit picks rising/high or falling/low. An any-edge bit makes an edge-typed pin fire on both transitions. Latched events sit in a status word that software clears by writing ones. A pin whose status bit is set and whose mask bit is clear is pending, and the single interrupt line is the OR of all pending pins, driven from a register.

The mask word is read-only on the bus. Software changes it through two write-only ports: one clears mask bits where ones are written, and the other sets them. Masking never stops detection. A pin that fires while masked keeps its status bit, and that event reaches the interrupt line as soon as the pin is unmasked. So software normally clears the status bit before it unmasks a pin.

The bank occupies a window at 0x200 plus 0x40 times the bank index on a simple single-cycle register bus. Writes take effect at the clock edge where they are presented. Reads return data one cycle after the request.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the mask word reads all ones, the status, type, polarity and any-edge words read zero, and the interrupt output is 0.
- R2: A write to the enable port (bank offset 0x10) clears every mask bit that is 1 in the written data. Mask bits under zero data bits keep their value.
- R3: A write to the disable port (bank offset 0x14) sets every mask bit that is 1 in the written data. Mask bits under zero data bits keep their value.
- R4: Writing to the status word (offset 0x18) clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R5: With type bit 1 (edge, offset 0x1C) and any-edge bit 0 (offset 0x24), a pin latches on a 0-to-1 change when its polarity bit (offset 0x20) is 1, and on a 1-to-0 change when it is 0. The opposite transition latches nothing.
- R6: With type bit 1 and any-edge bit 1, a pin latches on both transitions, whatever its polarity bit holds.
- R7: With type bit 0 (level), a pin latches while it sits at 1 if polarity is 1, or at 0 if polarity is 0. Any-edge has no effect. The bit is set again on every clock while the level persists, so a clear only holds once the level is gone.
- R8: Events are latched while a pin is masked (mask bit 1) and do not drive the interrupt output. Once the pin is unmasked, the held event drives the output.
- R9: The interrupt output is the OR over pins of (status AND NOT mask), registered. It changes on the clock edge after the edge that changed status or mask.
- R10: When an event and a status clear hit the same bit in the same cycle, the bit is left set.
- R11: A read returns the addressed word on the cycle after the request. Reads of the enable and disable ports return zero, and writes to the mask word's own address (offset 0x0C) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NPIN | Synchronized GPIO pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | NPIN | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | NPIN | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The assertions check these rules on every cycle:
- the enable and disable ports act bit by bit on the mask (R2, R3);
- a status clear takes out only bits with no new event (R4);
- a new event always survives a clear in the same cycle (R10);
- the output is quiet while every pin is masked, and it is raised only when a pin was pending on the previous cycle (R8, R9).

The bench scenarios are needed for the rest:
- the trigger decode for each type/polarity/any-edge combination (R5, R6, R7);
- level persistence under repeated clears (R7);
- a masked event appearing on the output at the expected cycle after unmask (R8, R9);
- the read latency and the behaviour of write-only and read-only addresses (R11).

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Bank window and word offsets within the bank
  localparam int BANK_BASE   = 'h200;
  localparam int BANK_STRIDE = 'h40;
  localparam int OFF_MASK    = 'h0C;
  localparam int OFF_ENA     = 'h10;
  localparam int OFF_DIS     = 'h14;
  localparam int OFF_STS     = 'h18;
  localparam int OFF_TYPE    = 'h1C;
  localparam int OFF_POL     = 'h20;
  localparam int OFF_ANY     = 'h24;

  function automatic int word_addr(input int bank, input int off);
    return BANK_BASE + BANK_STRIDE * bank + off;
  endfunction

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK, SEL_STS, SEL_TYPE, SEL_POL, SEL_ANY
  } rd_sel_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
// Trigger configuration words and the set/clear-port mask word
module gpio_irq_cfg #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 12,
  parameter int BANK_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NPIN-1:0]   wr_data_i,
  output logic [NPIN-1:0]   type_q,
  output logic [NPIN-1:0]   pol_q,
  output logic [NPIN-1:0]   any_q,
  output logic [NPIN-1:0]   mask_q
);
  import gpio_irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(word_addr(BANK_IDX, OFF_ENA));
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(word_addr(BANK_IDX, OFF_DIS));
  localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(word_addr(BANK_IDX, OFF_TYPE));
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(word_addr(BANK_IDX, OFF_POL));
  localparam logic [ADDR_W-1:0] A_ANY  = ADDR_W'(word_addr(BANK_IDX, OFF_ANY));

  logic wr_ena, wr_dis, wr_type, wr_pol, wr_any;

  always_comb begin
    wr_ena  = wr_en_i && (wr_addr_i == A_ENA);
    wr_dis  = wr_en_i && (wr_addr_i == A_DIS);
    wr_type = wr_en_i && (wr_addr_i == A_TYPE);
    wr_pol  = wr_en_i && (wr_addr_i == A_POL);
    wr_any  = wr_en_i && (wr_addr_i == A_ANY);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      type_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
    end else begin
      if (wr_type) type_q <= wr_data_i;
      if (wr_pol)  pol_q  <= wr_data_i;
      if (wr_any)  any_q  <= wr_data_i;
    end
  end

  // Mask: ones in enable data clear, ones in disable data set
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mask_q <= '1;
    end else if (wr_ena) begin
      mask_q <= mask_q & ~wr_data_i;
    end else if (wr_dis) begin
      mask_q <= mask_q | wr_data_i;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin trigger decode against the previous sampled level
module gpio_irq_detect #(
  parameter int NPIN = 32
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] type_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] any_i,
  output logic [NPIN-1:0] hit_o
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= pin_i;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic rise, fall, lvl;
    always_comb begin
      rise = pin_i[i] & ~prev_q[i];
      fall = ~pin_i[i] & prev_q[i];
      lvl  = pol_i[i] ? pin_i[i] : ~pin_i[i];
      if (!type_i[i])     hit_o[i] = lvl;
      else if (any_i[i])  hit_o[i] = rise | fall;
      else if (pol_i[i])  hit_o[i] = rise;
      else                hit_o[i] = fall;
    end
  end
endmodule

// File: rtl/gpio_irq_latch.sv
// Status word: set by events, cleared by write-one; events win
module gpio_irq_latch #(
  parameter int NPIN = 32
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [NPIN-1:0] hit_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] sts_q
);
  always_ff @(posedge clk_i) begin
    if (rst_i) sts_q <= '0;
    else       sts_q <= (sts_q & ~clr_i) | hit_i;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int NPIN     = 32,
  parameter int ADDR_W   = 12,
  parameter int BANK_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NPIN-1:0]   wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NPIN-1:0]   rd_data_o,
  output logic              irq_o
);
  import gpio_irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(word_addr(BANK_IDX, OFF_MASK));
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(word_addr(BANK_IDX, OFF_STS));
  localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(word_addr(BANK_IDX, OFF_TYPE));
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(word_addr(BANK_IDX, OFF_POL));
  localparam logic [ADDR_W-1:0] A_ANY  = ADDR_W'(word_addr(BANK_IDX, OFF_ANY));

  logic [NPIN-1:0] type_q, pol_q, any_q, mask_q;
  logic [NPIN-1:0] hit, sts_q, sts_clr;
  logic            irq_q;
  logic [NPIN-1:0] rd_q;
  rd_sel_e         rd_sel;

  gpio_irq_cfg #(.NPIN(NPIN), .ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX)) u_cfg (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .type_q    (type_q),
    .pol_q     (pol_q),
    .any_q     (any_q),
    .mask_q    (mask_q)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_det (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .pin_i  (pin_i),
    .type_i (type_q),
    .pol_i  (pol_q),
    .any_i  (any_q),
    .hit_o  (hit)
  );

  assign sts_clr = (wr_en_i && (wr_addr_i == A_STS)) ? wr_data_i : '0;

  gpio_irq_latch #(.NPIN(NPIN)) u_sts (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .hit_i (hit),
    .clr_i (sts_clr),
    .sts_q (sts_q)
  );

  // Registered combined interrupt
  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= 1'b0;
    else       irq_q <= |(sts_q & ~mask_q);
  end
  assign irq_o = irq_q;

  // Read decode; write-only ports fall to SEL_NONE and return zero
  always_comb begin
    unique case (rd_addr_i)
      A_MASK:  rd_sel = SEL_MASK;
      A_STS:   rd_sel = SEL_STS;
      A_TYPE:  rd_sel = SEL_TYPE;
      A_POL:   rd_sel = SEL_POL;
      A_ANY:   rd_sel = SEL_ANY;
      default: rd_sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      case (rd_sel)
        SEL_MASK: rd_q <= mask_q;
        SEL_STS:  rd_q <= sts_q;
        SEL_TYPE: rd_q <= type_q;
        SEL_POL:  rd_q <= pol_q;
        SEL_ANY:  rd_q <= any_q;
        default:  rd_q <= '0;
      endcase
    end
  end
  assign rd_data_o = rd_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NPIN     = 32,
  parameter int ADDR_W   = 12,
  parameter int BANK_IDX = 0
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [NPIN-1:0]   wr_data_i,
  input logic [NPIN-1:0]   hit,
  input logic [NPIN-1:0]   sts_q,
  input logic [NPIN-1:0]   mask_q,
  input logic              irq_o
);
  import gpio_irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(word_addr(BANK_IDX, OFF_ENA));
  localparam logic [ADDR_W-1:0] A_DIS = ADDR_W'(word_addr(BANK_IDX, OFF_DIS));
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(word_addr(BANK_IDX, OFF_STS));

  logic w_ena, w_dis, w_sts;
  assign w_ena = wr_en_i && (wr_addr_i == A_ENA);
  assign w_dis = wr_en_i && (wr_addr_i == A_DIS);
  assign w_sts = wr_en_i && (wr_addr_i == A_STS);

  a_r2_enable_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    w_ena |=> ((mask_q & $past(wr_data_i)) == '0));

  a_r3_disable_sets: assert property (@(posedge clk_i) disable iff (rst_i)
    w_dis |=> ((mask_q & $past(wr_data_i)) == $past(wr_data_i)));

  a_r4_clear_takes: assert property (@(posedge clk_i) disable iff (rst_i)
    w_sts |=> ((sts_q & $past(wr_data_i & ~hit)) == '0));

  a_r10_event_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((sts_q & $past(hit)) == $past(hit)));

  a_r8_all_masked_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (&mask_q) |=> !irq_o);

  a_r9_irq_needs_pending: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_o) |-> $past((sts_q & ~mask_q) != '0));
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .hit       (hit),
  .sts_q     (sts_q),
  .mask_q    (mask_q),
  .irq_o     (irq_o)
);

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 32;
  localparam int AW   = 12;

  localparam logic [AW-1:0] A_MASK = 12'h20C;
  localparam logic [AW-1:0] A_ENA  = 12'h210;
  localparam logic [AW-1:0] A_DIS  = 12'h214;
  localparam logic [AW-1:0] A_STS  = 12'h218;
  localparam logic [AW-1:0] A_TYPE = 12'h21C;
  localparam logic [AW-1:0] A_POL  = 12'h220;
  localparam logic [AW-1:0] A_ANY  = 12'h224;

  // [5] type [4] pol [3] any [2] level before [1] level after [0] expect event
  localparam int NVEC = 10;
  localparam logic [5:0] TBL [NVEC] = '{
    6'b110011, 6'b110100, 6'b100101, 6'b100010, 6'b101011,
    6'b111101, 6'b010111, 6'b010000, 6'b000001, 6'b001110
  };

  logic clk = 1'b0;
  logic rst;
  logic [NPIN-1:0] pins;
  logic wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [NPIN-1:0] wr_data, rd_data;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_unit #(.NPIN(NPIN), .ADDR_W(AW), .BANK_IDX(0)) u_dut (
    .clk_i(clk), .rst_i(rst), .pin_i(pins),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NPIN-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NPIN-1:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic cfg(input logic [NPIN-1:0] t, input logic [NPIN-1:0] p, input logic [NPIN-1:0] a);
    wr(A_POL, p); wr(A_ANY, a); wr(A_TYPE, t);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NPIN-1:0] v;
    rst = 1'b1; pins = '1; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    idle(3);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, '0);
    rd(A_MASK, v); chk("R1 mask", v, '1);
    rd(A_STS, v);  chk("R1 status", v, '0);
    rd(A_TYPE, v); chk("R1 type", v, '0);
    rd(A_POL, v);  chk("R1 polarity", v, '0);
    rd(A_ANY, v);  chk("R1 any", v, '0);

    // Trigger decode table on pin 0 (R5 R6 R7)
    for (int i = 0; i < NVEC; i++) begin
      cfg({31'b0, TBL[i][5]}, {31'b0, TBL[i][4]}, {31'b0, TBL[i][3]});
      @(negedge clk) pins[0] = TBL[i][2];
      idle(2);
      wr(A_STS, '1);
      @(negedge clk) pins[0] = TBL[i][1];
      idle(1);
      rd(A_STS, v);
      chk($sformatf("R5 R6 R7 trigger row %0d", i), v, {31'b0, TBL[i][0]});
    end
    @(negedge clk) pins = '1;
    cfg('0, '0, '0);
    wr(A_STS, '1);

    // R2 / R3 mask ports
    wr(A_ENA, 32'h0000_00F0);
    rd(A_MASK, v); chk("R2 enable clears", v, 32'hFFFF_FF0F);
    wr(A_ENA, 32'h0);
    rd(A_MASK, v); chk("R2 zero data unchanged", v, 32'hFFFF_FF0F);
    wr(A_DIS, 32'h0000_0030);
    rd(A_MASK, v); chk("R3 disable sets", v, 32'hFFFF_FF3F);
    wr(A_DIS, '1);
    rd(A_MASK, v); chk("R3 disable all", v, '1);

    // R11 read-only mask and write-only ports
    wr(A_MASK, 32'h0);
    rd(A_MASK, v); chk("R11 mask write ignored", v, '1);
    rd(A_ENA, v);  chk("R11 enable reads zero", v, '0);
    rd(A_DIS, v);  chk("R11 disable reads zero", v, '0);

    // R8 masked event is latched; R9 output timing on unmask and clear
    cfg(32'h0000_0060, 32'h0000_0020, 32'h0000_0040);
    @(negedge clk) pins[6:5] = 2'b00;
    idle(2);
    wr(A_STS, '1);
    @(negedge clk) pins[5] = 1'b1;
    idle(3);
    chk("R8 masked no irq", {31'b0, irq}, '0);
    rd(A_STS, v); chk("R8 latched while masked", v, 32'h0000_0020);
    wr(A_ENA, 32'h0000_0020);
    chk("R9 irq one cycle after unmask", {31'b0, irq}, '0);
    @(negedge clk);
    chk("R8 R9 unmasked event raises irq", {31'b0, irq}, 32'h1);
    wr(A_STS, 32'h0000_0020);
    chk("R9 irq holds one cycle after clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq drops after clear", {31'b0, irq}, '0);

    // R4 partial clear: any-edge pin 6 and rising pin 5
    @(negedge clk) pins[5] = 1'b0;
    idle(1);
    @(negedge clk) begin pins[5] = 1'b1; pins[6] = 1'b1; end
    idle(1);
    wr(A_STS, 32'h0000_0020);
    rd(A_STS, v); chk("R4 write-one clears only bit 5", v, 32'h0000_0040);
    wr(A_STS, 32'h0000_0040);
    wr(A_DIS, '1);

    // R10 event and clear in the same cycle (pin 5 rising)
    @(negedge clk) pins[5] = 1'b0;
    idle(2);
    rd(A_STS, v); chk("R10 precondition clear", v, '0);
    @(negedge clk) begin
      pins[5] = 1'b1; wr_en = 1'b1; wr_addr = A_STS; wr_data = 32'h0000_0020;
    end
    @(negedge clk) begin wr_en = 1'b0; wr_data = '0; end
    rd(A_STS, v); chk("R10 event wins over clear", v, 32'h0000_0020);
    wr(A_STS, '1);

    // R7 level persistence on pin 3 (level high)
    cfg('0, 32'h0000_0008, 32'h0000_0008);
    idle(1);
    wr(A_STS, 32'h0000_0008);
    rd(A_STS, v); chk("R7 level persists after clear", v, 32'h0000_0008);
    @(negedge clk) pins[3] = 1'b0;
    idle(1);
    wr(A_STS, 32'h0000_0008);
    rd(A_STS, v); chk("R7 clear holds once level gone", v, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule